// File: doc/BRIEF.md
# Framed Transfer Word Packer

The packer takes one transfer of 1 to 256 bytes as a byte stream and turns it into a run of 36-bit words. Each word carries 32 payload bits and a 4-bit overhead nibble. The transfer's metadata has no header word of its own. Instead it is spread over the nibbles of the first four words: a start flag, the transfer length coded as byte count minus one, and the packet delineation and error flags. Unused payload bytes become 0xFF. The word count is raised to at least four and rounded up to an even number.

Because the length sits in the first word, the whole transfer is gathered into an internal word buffer before any word leaves. The control is a two-state machine. In `ST_FILL` the block accepts bytes. The transition *end of transfer* happens when the byte marked last is accepted, or when the 256th byte is accepted, and it leads to `ST_SEND`. In `ST_SEND` the block presents words. The transition *last word taken* happens when the final word completes its handshake, and it leads back to `ST_FILL`. Both sides use a valid/ready handshake.

Top module: `fwp_packer`

## Requirements
- R1: In `ST_FILL` a byte is accepted on each clock edge at which `in_valid` and `in_ready` are both high. A transfer ends at the accepted byte with `in_last` high, or at the 256th accepted byte even when `in_last` is low.
- R2: On the cycle after the ending byte is accepted, `out_valid` is 1 and `in_ready` is 0. On the cycle after the final word is accepted, `in_ready` is 1 and `out_valid` is 0.
- R3: For B bytes with P = ceil(B/4), the number of words sent is 4 when P < 4, and P rounded up to the next even number otherwise. `out_last` is high on the final word only.
- R4: `out_word[35:32]` is the overhead nibble and `out_word[31:0]` is the payload. Transfer byte k goes to word k/4, lane k%4. Lane j occupies bits [31-8j:24-8j], so the first byte lands in bits [31:24].
- R5: Every payload byte position at index B or higher, including positions in words that follow the payload entirely, holds 0xFF.
- R6: With L = B-1 as 8 bits, the nibble of word 0 is {1, L[7:5]}. Its top bit is the start flag.
- R7: The nibble of word 1 is {0, L[4:2]}.
- R8: The nibble of word 2 is {sop, eop, err, 0}. The three flags are taken from `in_sop`, `in_eop` and `in_err` on the byte that ends the transfer.
- R9: The nibble of word 3 is {0, 0, L[1:0]}.
- R10: The nibble of every word after word 3 is 4'b0000.
- R11: While `out_valid` is high and `out_ready` is low, `out_word` and `out_last` hold their values.
- R12: After reset `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block accepts bytes (`ST_FILL`) |
| in_byte | input | 8 | Byte of the transfer, in order |
| in_last | input | 1 | Byte closes the transfer |
| in_sop | input | 1 | Packet start flag, taken with the closing byte |
| in_eop | input | 1 | Packet end flag, taken with the closing byte |
| in_err | input | 1 | Error flag, taken with the closing byte |
| out_valid | output | 1 | Word offered (`ST_SEND`) |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 36 | {overhead nibble, payload[31:0]} |
| out_last | output | 1 | Final word of the transfer |

## Verification
The assertions assume that `in_sop`, `in_eop` and `in_err` are meaningful only alongside the closing byte. They also assume that downstream may hold `out_ready` low for any number of cycles, and they check that the offered word does not change during such a stall. The stimulus drives inputs only on falling edges and keeps `in_valid` and its byte steady until a handshake. It draws lengths, byte values, flags, idle gaps and ready gaps from a seeded `$urandom`. Directed transfers cover the lengths around the four-word minimum and the even rounding, plus a 256-byte transfer that never raises `in_last`.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    localparam int FWP_MAX_BYTES = 256;
    localparam int FWP_LANES     = 4;
    localparam int FWP_BYTE_W    = 8;
    localparam int FWP_OVH_W     = 4;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_SEND = 1'b1
    } fwp_state_t;
endpackage

// File: rtl/fwp_word_buf.sv
module fwp_word_buf #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fwp_gather.sv
module fwp_gather #(
    parameter int MAX_BYTES = 256,
    parameter int LANES     = 4,
    parameter int BYTE_W    = 8,
    localparam int WORD_W   = LANES * BYTE_W,
    localparam int LW       = $clog2(LANES),
    localparam int PW       = $clog2(MAX_BYTES / LANES),
    localparam int LEN_W    = PW + LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              last_in,
    output logic              wr_en,
    output logic [PW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic [LEN_W-1:0]  len_m1
);
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

    logic [WORD_W-1:0] acc;
    logic [LW-1:0]     bidx;
    logic [PW-1:0]     wptr;
    logic [WORD_W-1:0] merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = WORD_W - 1 - g * BYTE_W;
        assign merged[HI -: BYTE_W] = (bidx == LW'(g)) ? byte_in : acc[HI -: BYTE_W];
    end

    assign len_m1  = {wptr, bidx};
    assign done    = take && (last_in || (len_m1 == {LEN_W{1'b1}}));
    assign wr_en   = take && ((bidx == LAST_LANE) || done);
    assign wr_addr = wptr;
    assign wr_data = merged;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '1;
            bidx <= '0;
            wptr <= '0;
        end else if (take) begin
            acc <= wr_en ? {WORD_W{1'b1}} : merged;
            if (done) begin
                bidx <= '0;
                wptr <= '0;
            end else if (bidx == LAST_LANE) begin
                bidx <= '0;
                wptr <= wptr + 1'b1;
            end else begin
                bidx <= bidx + 1'b1;
            end
        end
    end

    // R1: a write to the top buffer slot always closes the transfer
    a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == {PW{1'b1}})) |-> done);
endmodule

// File: rtl/fwp_ovh_enc.sv
module fwp_ovh_enc #(
    parameter int PW    = 6,
    parameter int LEN_W = 8,
    parameter int OVH_W = 4
) (
    input  logic [PW-1:0]    idx,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             sop,
    input  logic             eop,
    input  logic             err,
    output logic [OVH_W-1:0] nib
);
    always_comb begin
        unique case (idx)
            PW'(0):  nib = {1'b1, len_m1[7:5]};
            PW'(1):  nib = {1'b0, len_m1[4:2]};
            PW'(2):  nib = {sop, eop, err, 1'b0};
            PW'(3):  nib = {2'b00, len_m1[1:0]};
            default: nib = '0;
        endcase
    end
endmodule

// File: rtl/fwp_packer.sv
module fwp_packer
    import fwp_pkg::*;
#(
    parameter int MAX_BYTES = FWP_MAX_BYTES,
    parameter int LANES     = FWP_LANES,
    parameter int BYTE_W    = FWP_BYTE_W,
    parameter int OVH_W     = FWP_OVH_W,
    localparam int WORD_W   = LANES * BYTE_W,
    localparam int OUT_W    = WORD_W + OVH_W,
    localparam int DEPTH    = MAX_BYTES / LANES,
    localparam int PW       = $clog2(DEPTH),
    localparam int LW       = $clog2(LANES),
    localparam int LEN_W    = PW + LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_word,
    output logic              out_last
);
    localparam logic [PW-1:0] MIN_LAST = PW'(3);

    fwp_state_t state, state_nx;

    logic              take, g_wr, g_done;
    logic [PW-1:0]     g_addr;
    logic [WORD_W-1:0] g_data, rd_data;
    logic [LEN_W-1:0]  g_len;

    logic [LEN_W-1:0]  len_q;
    logic [PW-1:0]     nlast_q, rptr;
    logic              sop_q, eop_q, err_q;
    logic [PW-1:0]     pw_last, nlast_nx;
    logic [OVH_W-1:0]  nib;
    logic              give;

    assign take = in_valid && in_ready;
    assign give = out_valid && out_ready;

    fwp_gather #(.MAX_BYTES(MAX_BYTES), .LANES(LANES), .BYTE_W(BYTE_W)) i_gather (
        .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_byte), .last_in(in_last),
        .wr_en(g_wr), .wr_addr(g_addr), .wr_data(g_data), .done(g_done), .len_m1(g_len)
    );

    fwp_word_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_buf (
        .clk(clk), .wr_en(g_wr), .wr_addr(g_addr), .wr_data(g_data),
        .rd_addr(rptr), .rd_data(rd_data)
    );

    fwp_ovh_enc #(.PW(PW), .LEN_W(LEN_W), .OVH_W(OVH_W)) i_enc (
        .idx(rptr), .len_m1(len_q), .sop(sop_q), .eop(eop_q), .err(err_q), .nib(nib)
    );

    // word count minus one: at least four words, even count
    assign pw_last = g_len[LEN_W-1 -: PW];
    always_comb begin
        if (pw_last < MIN_LAST)  nlast_nx = MIN_LAST;
        else if (pw_last[0])     nlast_nx = pw_last;
        else                     nlast_nx = pw_last + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: if (g_done) state_nx = ST_SEND;
            ST_SEND: if (give && out_last) state_nx = ST_FILL;
            default: state_nx = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            nlast_q <= MIN_LAST;
            rptr    <= '0;
            sop_q   <= 1'b0;
            eop_q   <= 1'b0;
            err_q   <= 1'b0;
        end else if (g_done) begin
            len_q   <= g_len;
            nlast_q <= nlast_nx;
            sop_q   <= in_sop;
            eop_q   <= in_eop;
            err_q   <= in_err;
            rptr    <= '0;
        end else if (give) begin
            rptr <= out_last ? '0 : rptr + 1'b1;
        end
    end

    always_comb begin
        in_ready  = (state == ST_FILL);
        out_valid = (state == ST_SEND);
        out_last  = out_valid && (rptr == nlast_q);
        out_word  = {nib, (rptr <= len_q[LEN_W-1 -: PW]) ? rd_data : {WORD_W{1'b1}}};
    end

    // R11: a stalled word stays put
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));
    // R2: the closing byte hands over to the send side
    a_r2_to_send: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (out_valid && !in_ready));
    // R2: taking the final word reopens the input
    a_r2_to_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));
    // R3: final word index is odd and at least three
    a_r3_even_min: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (rptr[0] && (rptr >= MIN_LAST)));
    // R6: first word carries the start flag
    a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (rptr == '0)) |-> out_word[OUT_W-1]);
    // R10: tail nibbles are zero
    a_r10_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (rptr > MIN_LAST)) |-> (out_word[OUT_W-1 -: OVH_W] == '0));
endmodule

// File: tb/test_fwp_packer.sv
module test_fwp_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = '0;
    logic        in_last = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        in_err = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [35:0] out_word;
    logic        out_last;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [7:0] tx [256];
    int seed_dummy;

    always #10 clk = ~clk;

    fwp_packer i_fwp_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_last(in_last), .in_sop(in_sop), .in_eop(in_eop),
        .in_err(in_err), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int exp_words(input int b);
        int p;
        p = (b + 3) / 4;
        if (p < 4) return 4;
        return p + (p % 2);
    endfunction

    function automatic logic [3:0] exp_nib(input int i, input int b,
                                           input bit s, input bit e, input bit r);
        logic [7:0] l;
        l = 8'(b - 1);
        case (i)
            0: return {1'b1, l[7:5]};
            1: return {1'b0, l[4:2]};
            2: return {s, e, r, 1'b0};
            3: return {2'b00, l[1:0]};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] exp_pay(input int i, input int b);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) begin
            int k;
            k = i * 4 + j;
            w[31 - 8*j -: 8] = (k < b) ? tx[k] : 8'hFF;
        end
        return w;
    endfunction

    task automatic run_xfer(input int b, input bit use_last, input bit s,
                            input bit e, input bit r, input int gap);
        int nw, idx;
        bit done, held, hs;
        logic [35:0] prev_w;
        logic prev_l;
        for (int k = 0; k < b; k++) tx[k] = 8'($urandom);
        // R1: offer bytes with random idle gaps
        for (int k = 0; k < b; k++) begin
            if (gap > 0) begin
                int g;
                g = $urandom % (gap + 1);
                for (int c = 0; c < g; c++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
            end
            hs = 1'b0;
            while (!hs) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_byte  = tx[k];
                in_last  = use_last && (k == b - 1);
                in_sop   = (k == b - 1) ? s : 1'($urandom);
                in_eop   = (k == b - 1) ? e : 1'($urandom);
                in_err   = (k == b - 1) ? r : 1'($urandom);
                hs = in_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (use_last)
            chk(out_valid && !in_ready, "R2", "send side after closing byte",
                36'({out_valid, in_ready}), 36'b10);
        else
            chk(out_valid && !in_ready, "R1", "forced close at 256th byte",
                36'({out_valid, in_ready}), 36'b10);
        nw = exp_words(b);
        idx = 0;
        done = 1'b0;
        held = 1'b0;
        prev_w = '0;
        prev_l = 1'b0;
        while (!done) begin
            out_ready = ($urandom % 4) != 0;
            if (out_valid) begin
                if (held)
                    chk(out_word == prev_w && out_last == prev_l, "R11", "stall hold",
                        out_word, prev_w);
                prev_w = out_word;
                prev_l = out_last;
                held = !out_ready;
                if (out_ready) begin
                    logic [3:0] en;
                    string rq;
                    en = exp_nib(idx, b, s, e, r);
                    rq = (idx == 0) ? "R6" : (idx == 1) ? "R7" : (idx == 2) ? "R8" :
                         (idx == 3) ? "R9" : "R10";
                    chk(out_word[35:32] == en, rq, $sformatf("nibble word %0d len %0d", idx, b),
                        36'(out_word[35:32]), 36'(en));
                    chk(out_word[31:0] == exp_pay(idx, b),
                        ((idx + 1) * 4 > b) ? "R5" : "R4",
                        $sformatf("payload word %0d len %0d", idx, b),
                        36'(out_word[31:0]), 36'(exp_pay(idx, b)));
                    chk(out_last == (idx == nw - 1), "R3", $sformatf("last flag word %0d", idx),
                        36'(out_last), 36'(idx == nw - 1));
                    if (out_last) done = 1'b1;
                    idx++;
                    if (idx > nw) begin
                        chk(1'b0, "R3", "runaway word count", 36'(idx), 36'(nw));
                        done = 1'b1;
                    end
                end
            end
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(idx == nw, "R3", $sformatf("word count len %0d", b), 36'(idx), 36'(nw));
        chk(in_ready && !out_valid, "R2", "input reopened after final word",
            36'({in_ready, out_valid}), 36'b10);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        seed_dummy = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R12", "reset state",
            36'({in_ready, out_valid}), 36'b10);
        run_xfer(1,   1'b1, 1'b1, 1'b0, 1'b0, 0);
        run_xfer(2,   1'b1, 1'b0, 1'b1, 1'b1, 1);
        run_xfer(4,   1'b1, 1'b1, 1'b1, 1'b0, 0);
        run_xfer(5,   1'b1, 1'b0, 1'b0, 1'b1, 2);
        run_xfer(12,  1'b1, 1'b1, 1'b0, 1'b1, 0);
        run_xfer(13,  1'b1, 1'b0, 1'b1, 1'b0, 1);
        run_xfer(16,  1'b1, 1'b1, 1'b1, 1'b1, 0);
        run_xfer(17,  1'b1, 1'b0, 1'b0, 1'b0, 0);
        run_xfer(21,  1'b1, 1'b1, 1'b0, 1'b0, 3);
        run_xfer(255, 1'b1, 1'b0, 1'b1, 1'b0, 0);
        run_xfer(256, 1'b1, 1'b1, 1'b1, 1'b1, 1);
        run_xfer(256, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        run_xfer(3,   1'b1, 1'b1, 1'b0, 1'b0, 0);
        for (int t = 0; t < 24; t++) begin
            run_xfer(1 + int'($urandom % 256), 1'b1, 1'($urandom), 1'($urandom),
                     1'($urandom), int'($urandom % 3));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule